// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, on every clock, which of several hardware threads may issue an instruction into a shared pipeline. Each thread reports three flags: whether it has an instruction ready, whether it is held by a short stall, and whether it is waiting on a costly stall such as an L2 or L3 miss. The block answers with a one-hot grant, the index of the granted thread (used elsewhere to select that thread's program counter and register file) and a flag that marks pipeline bubble cycles.

Two interleaving policies share the same selection logic. In fine-grained mode the block rotates through the threads round-robin, starting just after the last granted thread and passing over any thread that cannot issue in that cycle, so the issuing thread normally changes every clock. In coarse-grained mode one thread owns the pipeline until it reports a costly stall. Short stalls only pause it. A costly stall hands the pipeline to the next eligible thread in round-robin order, and a fixed number of refill bubble cycles follows before the new thread issues.

Top module: `mtsel_issue_select`

## Requirements
- R1: After reset no bubble is signalled, the mode is fine-grained and the last-granted pointer names the highest-numbered thread, so the first fine-grained grant goes to thread 0 when it is eligible.
- R2: A thread is eligible in a cycle when its ready flag is 1 and both its short-stall and costly-stall flags are 0. Grants go only to eligible threads. The grant vector has at most one bit set, `issue_valid_o` is 1 exactly when a bit is set, and `issue_tid_o` gives that bit's index (0 when nothing is granted).
- R3: In fine-grained mode the grant goes to the first eligible thread in the order last+1, last+2, ... wrapping modulo the thread count, with the last granted thread itself considered last. The pointer then moves to the granted thread.
- R4: In fine-grained mode, when no thread is eligible, nothing is granted and the pointer keeps its value.
- R5: In coarse-grained mode the current thread (the pointer) is granted whenever it is eligible. A short stall or a cleared ready flag on it produces no grant and no switch.
- R6: In coarse-grained mode, when the current thread raises a costly stall and another thread is eligible, that cycle grants nothing, the pointer moves to the first eligible thread in round-robin order after the current one, and exactly `BUBBLE_CYCLES` cycles with `bubble_o` = 1 and no grant follow before the new thread can be granted.
- R7: In coarse-grained mode, when the current thread raises a costly stall and no other thread is eligible, nothing is granted, no bubble starts and the pointer does not move.
- R8: The mode input (0 = fine-grained, 1 = coarse-grained) is registered: a change applies from the following cycle, a change of mode never starts a bubble, and entering fine-grained mode ends any bubble in progress.
- R9: During a coarse-grained bubble the per-thread flags are ignored: the chosen thread stays selected and the bubble runs its full length whatever the flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_coarse_i | input | 1 | 0 selects fine-grained, 1 coarse-grained interleaving |
| thr_ready_i | input | NUM_THREADS | Per-thread instruction ready |
| thr_short_stall_i | input | NUM_THREADS | Per-thread short stall |
| thr_long_stall_i | input | NUM_THREADS | Per-thread costly stall (L2/L3 miss) |
| issue_grant_o | output | NUM_THREADS | One-hot grant of the issuing thread |
| issue_tid_o | output | TID_W | Index of the granted thread |
| issue_valid_o | output | 1 | A thread issues this cycle |
| bubble_o | output | 1 | Refill bubble after a coarse-grained switch |

## Verification
The assertions watch, on every cycle, that the grant is one-hot and lands on an eligible thread, that bubble cycles carry no grant, that the pointer holds when fine-grained mode finds nothing and when the coarse thread only has a short stall, that a switch is always followed by a bubble and that a mode change or a switch with no candidate never starts one. The exact round-robin order, the length of the bubble, the one-cycle delay on the mode input and the disregard of the flags during a bubble need the bench's per-cycle reference model across its directed and mixed scenarios.

// File: rtl/mtsel_pkg.sv
package mtsel_pkg;

  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } issue_mode_e;

  // A thread can issue only when ready and free of both kinds of stall.
  function automatic logic thread_can_issue(input logic rdy,
                                            input logic short_st,
                                            input logic long_st);
    return rdy & ~short_st & ~long_st;
  endfunction

endpackage

// File: rtl/mtsel_eligibility.sv
module mtsel_eligibility #(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [NUM_THREADS-1:0] short_i,
  input  logic [NUM_THREADS-1:0] long_i,
  output logic [NUM_THREADS-1:0] elig_o
);
  import mtsel_pkg::*;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig_o[t] = thread_can_issue(ready_i[t], short_i[t], long_i[t]);
  end

endmodule

// File: rtl/mtsel_rr_pick.sv
module mtsel_rr_pick #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0] req_i,
  input  logic [TID_W-1:0]       base_i,
  output logic                   found_o,
  output logic [TID_W-1:0]       idx_o,
  output logic [NUM_THREADS-1:0] onehot_o
);

  // Search starts one past the base and wraps; the base itself comes last.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      int j;
      j = (int'(base_i) + k) % NUM_THREADS;
      if (!found_o && req_i[j]) begin
        found_o = 1'b1;
        idx_o   = TID_W'(j);
      end
    end
  end

  always_comb begin
    onehot_o = '0;
    if (found_o) onehot_o[idx_o] = 1'b1;
  end

endmodule

// File: rtl/mtsel_bubble_timer.sv
module mtsel_bubble_timer #(
  parameter int BUBBLE_CYCLES = 3,
  localparam int CNT_W = $clog2(BUBBLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  output logic active_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= CNT_W'(BUBBLE_CYCLES);
    else if (clear_i)    cnt_q <= '0;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R6: a switch always opens a bubble in the following cycle
  p_switch_opens_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> active_o);

endmodule

// File: rtl/mtsel_issue_select.sv
module mtsel_issue_select #(
  parameter int NUM_THREADS   = 4,
  parameter int BUBBLE_CYCLES = 3,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_coarse_i,
  input  logic [NUM_THREADS-1:0] thr_ready_i,
  input  logic [NUM_THREADS-1:0] thr_short_stall_i,
  input  logic [NUM_THREADS-1:0] thr_long_stall_i,
  output logic [NUM_THREADS-1:0] issue_grant_o,
  output logic [TID_W-1:0]       issue_tid_o,
  output logic                   issue_valid_o,
  output logic                   bubble_o
);
  import mtsel_pkg::*;

  issue_mode_e            mode_q;
  logic [TID_W-1:0]       last_ptr_q;
  logic [NUM_THREADS-1:0] elig;
  logic                   pick_found;
  logic [TID_W-1:0]       pick_idx;
  logic [NUM_THREADS-1:0] pick_onehot;
  logic                   bub_active;

  // Named internal events for the assertions
  logic                   is_coarse;
  logic                   in_bubble;
  logic                   cur_long;
  logic                   cur_elig;
  logic                   switch_evt;
  logic                   grant_vld;
  logic [TID_W-1:0]       grant_idx;

  mtsel_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .ready_i (thr_ready_i),
    .short_i (thr_short_stall_i),
    .long_i  (thr_long_stall_i),
    .elig_o  (elig)
  );

  mtsel_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .req_i    (elig),
    .base_i   (last_ptr_q),
    .found_o  (pick_found),
    .idx_o    (pick_idx),
    .onehot_o (pick_onehot)
  );

  mtsel_bubble_timer #(.BUBBLE_CYCLES(BUBBLE_CYCLES)) u_bub (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (switch_evt),
    .clear_i  (!is_coarse),
    .active_o (bub_active)
  );

  assign is_coarse = (mode_q == MODE_COARSE);
  assign in_bubble = is_coarse && bub_active;
  assign cur_long  = thr_long_stall_i[last_ptr_q];
  assign cur_elig  = elig[last_ptr_q];

  always_comb begin
    grant_vld  = 1'b0;
    grant_idx  = '0;
    switch_evt = 1'b0;
    if (!is_coarse) begin
      grant_vld = pick_found;
      grant_idx = pick_idx;
    end else if (!in_bubble) begin
      if (cur_long) begin
        switch_evt = pick_found;
      end else if (cur_elig) begin
        grant_vld = 1'b1;
        grant_idx = last_ptr_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_FINE;
      last_ptr_q <= TID_W'(NUM_THREADS - 1);
    end else begin
      mode_q <= mode_coarse_i ? MODE_COARSE : MODE_FINE;
      if ((!is_coarse && pick_found) || switch_evt) last_ptr_q <= pick_idx;
    end
  end

  always_comb begin
    issue_grant_o = '0;
    if (grant_vld) issue_grant_o[grant_idx] = 1'b1;
  end
  assign issue_tid_o   = grant_idx;
  assign issue_valid_o = grant_vld;
  assign bubble_o      = in_bubble;

  // R2: at most one thread granted
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_grant_o));

  // R2: grant only to threads the per-thread flags allow
  p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant_o & ~elig) == '0);

  // R6: no issue during a refill bubble
  p_bubble_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |-> !issue_valid_o);

  // R4: fine mode with nothing eligible keeps the pointer
  p_fine_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_coarse && elig == '0) |=> $stable(last_ptr_q));

  // R5: coarse owner without a costly stall keeps the pipeline
  p_coarse_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_coarse && !in_bubble && !cur_long) |=> $stable(last_ptr_q));

  // R5: back-to-back coarse grants come from the same thread
  p_coarse_same_tid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_coarse && issue_valid_o && $past(is_coarse) && $past(issue_valid_o))
      |-> issue_tid_o == $past(issue_tid_o));

  // R7: costly stall with no candidate stays idle without a bubble
  p_idle_no_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_coarse && !in_bubble && cur_long && !pick_found)
      |=> (!bubble_o && $stable(last_ptr_q)));

  // R8: a mode change alone never opens a bubble
  p_mode_no_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_coarse_i != is_coarse) && !in_bubble && !switch_evt) |=> !bubble_o);

  // R9: the selected thread does not change during a bubble
  p_bubble_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_bubble |=> $stable(last_ptr_q));

endmodule

// File: tb/sim_mtsel_issue_select.sv
`timescale 1ns/1ps
module sim_mtsel_issue_select;
  localparam int N   = 4;
  localparam int BUB = 3;
  localparam int TW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic md = 1'b0;
  logic [N-1:0] rdy = '0, sst = '0, lst = '0;
  logic [N-1:0] grant;
  logic [TW-1:0] tid;
  logic vld, bub;

  always #2 clk = ~clk;

  mtsel_issue_select #(.NUM_THREADS(N), .BUBBLE_CYCLES(BUB)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_coarse_i(md),
    .thr_ready_i(rdy), .thr_short_stall_i(sst), .thr_long_stall_i(lst),
    .issue_grant_o(grant), .issue_tid_o(tid), .issue_valid_o(vld), .bubble_o(bub)
  );

  int compared = 0, mismatched = 0;

  // Reference model state
  int m_mode = 0, m_ptr = N - 1, m_left = 0;
  int e_vld, e_tid, e_bub;

  function automatic bit can_go(int t);
    return rdy[t] && !sst[t] && !lst[t];
  endfunction

  task automatic model_step();
    int nptr, nleft, cand;
    e_vld = 0; e_tid = 0; e_bub = 0;
    nptr = m_ptr; nleft = m_left; cand = -1;
    for (int k = 1; k <= N; k++)
      if (cand < 0 && can_go((m_ptr + k) % N)) cand = (m_ptr + k) % N;
    if (m_mode == 0) begin
      nleft = 0;
      if (cand >= 0) begin e_vld = 1; e_tid = cand; nptr = cand; end
    end else if (m_left > 0) begin
      e_bub = 1; nleft = m_left - 1;
    end else if (lst[m_ptr]) begin
      if (cand >= 0) begin nptr = cand; nleft = BUB; end
    end else if (can_go(m_ptr)) begin
      e_vld = 1; e_tid = m_ptr;
    end
    m_mode = md; m_ptr = nptr; m_left = nleft;
  endtask

  task automatic check(string tag, bit ok, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic m, logic [N-1:0] r, logic [N-1:0] s, logic [N-1:0] l);
    logic [N-1:0] eg;
    @(negedge clk);
    md = m; rdy = r; sst = s; lst = l;
    #1;
    model_step();
    eg = e_vld ? (N'(1) << e_tid) : '0;
    compared++;
    if (vld !== 1'(e_vld) || tid !== TW'(e_tid) || grant !== eg || bub !== 1'(e_bub)) begin
      mismatched++;
      $display("FAIL %s: actual vld=%0d tid=%0d grant=%b bub=%0d expected vld=%0d tid=%0d grant=%b bub=%0d",
               tag, vld, tid, grant, bub, e_vld, e_tid, eg, e_bub);
    end
  endtask

  localparam logic [N-1:0] ALL = '1;
  localparam logic [N-1:0] NONE = '0;

  function automatic logic [N-1:0] cur_bit();
    return N'(1) << m_ptr;
  endfunction

  initial begin
    int bubbles;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", vld === 1'b0 && bub === 1'b0, "idle in reset", int'(vld) + int'(bub), 0);
    rst_n = 1'b1;

    // R1: first grant is thread 0
    cyc("R1", 0, ALL, NONE, NONE);
    check("R1", tid === 0 && vld === 1'b1, "first tid", int'(tid), 0);

    // R3: rotation with all ready, then with holes
    repeat (6) cyc("R3", 0, ALL, NONE, NONE);
    repeat (4) cyc("R3", 0, 4'b1010, NONE, NONE);
    // R2: short and costly stalls both exclude a thread
    repeat (4) cyc("R2", 0, ALL, 4'b0100, 4'b0001);
    repeat (3) cyc("R2", 0, 4'b1001, 4'b1000, NONE);

    // R4: nothing eligible, pointer holds
    repeat (3) cyc("R4", 0, NONE, NONE, NONE);
    repeat (2) cyc("R4", 0, 4'b0010, NONE, NONE);
    cyc("R4", 0, ALL, NONE, NONE);
    check("R4", tid === 2, "after hold", int'(tid), 2);

    // R8: mode change applies one cycle late
    cyc("R8", 1, ALL, NONE, NONE);
    check("R8", tid === 3, "still rotating", int'(tid), 3);
    cyc("R8", 1, ALL, NONE, NONE);
    check("R8", bub === 1'b0, "no bubble on mode change", int'(bub), 0);

    // R5: owner keeps issuing; short stall and not-ready only pause
    repeat (4) cyc("R5", 1, ALL, NONE, NONE);
    repeat (3) cyc("R5", 1, ALL, cur_bit(), NONE);
    cyc("R5", 1, ALL & ~cur_bit(), NONE, NONE);
    repeat (2) cyc("R5", 1, ALL, NONE, NONE);

    // R6: costly stall switches with an exact-length bubble
    cyc("R6", 1, ALL, NONE, cur_bit());
    bubbles = 0;
    for (int i = 0; i < BUB + 2; i++) begin
      cyc("R6", 1, ALL, NONE, NONE);
      if (bub === 1'b1) bubbles++;
    end
    check("R6", bubbles == BUB, "bubble length", bubbles, BUB);

    // R9: flags ignored during bubble
    cyc("R9", 1, ALL, NONE, cur_bit());
    cyc("R9", 1, NONE, ALL, ALL);
    cyc("R9", 1, ALL, NONE, ALL);
    cyc("R9", 1, 4'b0101, 4'b0011, NONE);
    repeat (3) cyc("R9", 1, ALL, NONE, NONE);

    // R7: costly stall with no candidate: idle, no bubble
    repeat (3) cyc("R7", 1, cur_bit(), NONE, cur_bit());
    cyc("R7", 1, cur_bit(), NONE, NONE);
    cyc("R7", 1, ALL, NONE, cur_bit());
    repeat (BUB + 1) cyc("R7", 1, ALL, NONE, NONE);

    // R8: leaving coarse mode during a bubble ends it
    cyc("R8", 1, ALL, NONE, cur_bit());
    cyc("R8", 0, ALL, NONE, NONE);
    repeat (3) cyc("R8", 0, ALL, NONE, NONE);

    // R2: mixed traffic across both modes
    for (int i = 0; i < 400; i++) begin
      logic m;
      m = ((i / 40) % 2) == 1;
      cyc("R2", m, N'($urandom) | N'($urandom), N'($urandom) & N'($urandom),
          N'($urandom) & N'($urandom) & N'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule